// File: doc/BRIEF.md
# Sleep Countdown Timer with Debug-Pin Wakeup

This block is a low-power countdown timer with a three-word register bank. A 32-bit counter, loaded by software, counts down by one on each tick pulse while the software enable is on. When the count reaches 1 the block raises its interrupt. The count keeps going past zero into negative values, so its top bit shows an overrun. Software can also ask for the interrupt to be set or cleared. Each request stays visible in its register bit until it has taken effect. Expiry beats a clear, and a set beats a clear.

A separate wakeup flag catches falling edges on a debug clock pin. It does so only while it is armed, the power domain is reported down and the debugger strap is high. The wakeup output is the OR of this flag and the timer interrupt, and a power controller uses it to bring the domain back up. Register reads return data in the same cycle. Writes take effect on the clock edge.

Top module: `sleep_timer_wake`

## Requirements
- R1: After reset, the words at 0x0, 0x4 and 0x8 all read zero, and `irq` and `wakeReq` are low.
- R2: The word at 0x8 reads and writes the whole 32-bit count. A write loads the counter directly.
- R3: While 0x0 bit 0 (software enable) is 1, each cycle with `tickEn` high lowers the count by one, wrapping from 0 to 0xFFFFFFFF. While the enable is 0 the count holds. Bit 5 of 0x0 and of 0x4 reads count bit 31.
- R4: A count equal to 1 sets the interrupt (0x4 bit 0 and `irq`) on the next clock edge.
- R5: Writing 1 to 0x4 bit 2 requests a set. The bit reads 1 until the interrupt is set on the following edge. Writing 0 has no effect.
- R6: Writing 1 to 0x4 bit 1 requests a clear. The bit reads 1 until the interrupt has been cleared. Writing 0 has no effect.
- R7: While the count equals 1 the interrupt stays set, and a pending clear stays pending until the count moves away from 1.
- R8: When set and clear are requested in the same write, the interrupt is set first, and the clear takes effect on the edge after that.
- R9: 0x4 bit 8 is set by a falling edge of `dbgClkPin`, seen through a two-flop synchronizer, only when 0x0 bit 24 is 1, `pwrDown` is 1 and `dbgEnable` is 1. Writing 1 to the bit clears it.
- R10: `wakeReq` is high whenever the interrupt or the debug wakeup flag is set.
- R11: 0x0 bits 0, 8, 9 and 24 read back what was written. Bit 7 of 0x0 and of 0x4 shows the software enable. Bit 6 of both shows `lpClkSts`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| tickEn | input | 1 | Count-down tick pulse |
| dbgClkPin | input | 1 | Debug clock pin, asynchronous |
| pwrDown | input | 1 | Power domain reported down |
| dbgEnable | input | 1 | Debugger-enable strap |
| lpClkSts | input | 1 | Low-power clock state, shown in status bits |
| irq | output | 1 | Timer interrupt |
| wakeReq | output | 1 | Wakeup request to the power controller |

## Verification
The interrupt register has three sources that can act in the same cycle: the expiry event, a pending set and a pending clear. The bench provokes each clash on purpose. It parks the count at 1 and then requests a clear. It writes both request bits in one write. It also moves the count off 1 while a clear is still waiting. Each outcome is judged by reading the control word on consecutive cycles: the pending bits and the interrupt state must change only on the cycles the priority order allows.

// File: rtl/sleep_timer_pkg.sv
package sleep_timer_pkg;
  typedef struct packed {
    logic loadCnt;
    logic runEn;
    logic dbgArm;
    logic dbgClr;
  } slpStrobe_t;

  localparam int BIT_SWEN   = 0;
  localparam int BIT_SIGN   = 5;
  localparam int BIT_LPCLK  = 6;
  localparam int BIT_ACTIVE = 7;
  localparam int BIT_SELP   = 8;
  localparam int BIT_SELLP  = 9;
  localparam int BIT_DBGEN  = 24;
  localparam int BIT_IRQ    = 0;
  localparam int BIT_CLRREQ = 1;
  localparam int BIT_SETREQ = 2;
  localparam int BIT_DBGFLG = 8;
endpackage

// File: rtl/slp_datapath.sv
module slp_datapath
  import sleep_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  slpStrobe_t       strb,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic             dbgClkPin,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             dbgFlag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES:0] syncQ;
  logic pinFall;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], dbgClkPin};
  end

  assign pinFall = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (strb.loadCnt) count <= wrData;
    else if (strb.runEn && tickEn) count <= count - ONE;
  end

  assign expire = (count == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) dbgFlag <= 1'b0;
    else if (strb.dbgArm && pinFall) dbgFlag <= 1'b1;
    else if (strb.dbgClr) dbgFlag <= 1'b0;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> count == $past(wrData)); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runEn && tickEn && !strb.loadCnt) |=> count == $past(count) - ONE); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runEn && !strb.loadCnt) |=> $stable(count)); // R3
  AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgFlag) |-> $past(strb.dbgArm)); // R9
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import sleep_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  input  logic              dbgFlag,
  input  logic              pwrDown,
  input  logic              dbgEnable,
  input  logic              lpClkSts,
  output slpStrobe_t        strb,
  output logic              irq,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] OFS_CTL1 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTL2 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(8);

  logic swEn, selP, selLp, dbgWakeEn, setPend, clrPend;
  logic wrCtl1, wrCtl2, sign;

  assign wrCtl1 = wrEn && (addr == OFS_CTL1);
  assign wrCtl2 = wrEn && (addr == OFS_CTL2);
  assign sign   = count[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn <= 1'b0; selP <= 1'b0; selLp <= 1'b0; dbgWakeEn <= 1'b0;
    end else if (wrCtl1) begin
      swEn      <= wrData[BIT_SWEN];
      selP      <= wrData[BIT_SELP];
      selLp     <= wrData[BIT_SELLP];
      dbgWakeEn <= wrData[BIT_DBGEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0; setPend <= 1'b0; clrPend <= 1'b0;
    end else begin
      if (expire || setPend) irq <= 1'b1;
      else if (clrPend) irq <= 1'b0;
      if (wrCtl2 && wrData[BIT_SETREQ]) setPend <= 1'b1;
      else if (setPend) setPend <= 1'b0;
      if (wrCtl2 && wrData[BIT_CLRREQ]) clrPend <= 1'b1;
      else if (clrPend && !expire && !setPend) clrPend <= 1'b0;
    end
  end

  always_comb begin
    strb.loadCnt = wrEn && (addr == OFS_CNT);
    strb.runEn   = swEn;
    strb.dbgArm  = dbgWakeEn && pwrDown && dbgEnable;
    strb.dbgClr  = wrCtl2 && wrData[BIT_DBGFLG];
  end

  always_comb begin
    rdData = '0;
    if (addr == OFS_CTL1) begin
      rdData[BIT_SWEN]   = swEn;
      rdData[BIT_SIGN]   = sign;
      rdData[BIT_LPCLK]  = lpClkSts;
      rdData[BIT_ACTIVE] = swEn;
      rdData[BIT_SELP]   = selP;
      rdData[BIT_SELLP]  = selLp;
      rdData[BIT_DBGEN]  = dbgWakeEn;
    end else if (addr == OFS_CTL2) begin
      rdData[BIT_IRQ]    = irq;
      rdData[BIT_CLRREQ] = clrPend;
      rdData[BIT_SETREQ] = setPend;
      rdData[BIT_SIGN]   = sign;
      rdData[BIT_LPCLK]  = lpClkSts;
      rdData[BIT_ACTIVE] = swEn;
      rdData[BIT_DBGFLG] = dbgFlag;
    end else if (addr == OFS_CNT) begin
      rdData = count;
    end
  end

  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> irq); // R4
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    setPend |=> irq); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrPend && !expire && !setPend) |=> !irq); // R6
  AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (clrPend && expire) |=> clrPend); // R7
  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (setPend && clrPend) |=> (irq && clrPend)); // R8
endmodule

// File: rtl/sleep_timer_wake.sv
module sleep_timer_wake
  import sleep_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  input  logic              dbgClkPin,
  input  logic              pwrDown,
  input  logic              dbgEnable,
  input  logic              lpClkSts,
  output logic              irq,
  output logic              wakeReq
);
  slpStrobe_t strb;
  logic [DATA_W-1:0] count;
  logic expire, dbgFlag;

  slp_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .expire(expire), .dbgFlag(dbgFlag), .pwrDown(pwrDown),
    .dbgEnable(dbgEnable), .lpClkSts(lpClkSts), .strb(strb), .irq(irq),
    .rdData(rdData)
  );

  slp_datapath #(.CNT_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tickEn(tickEn), .wrData(wrData),
    .dbgClkPin(dbgClkPin), .count(count), .expire(expire), .dbgFlag(dbgFlag)
  );

  assign wakeReq = irq | dbgFlag;

  AST_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> wakeReq); // R10
  AST_WAKE_DBG: assert property (@(posedge clk) disable iff (!rstN)
    dbgFlag |-> wakeReq); // R10
endmodule

// File: tb/sleep_timer_wake_bench.sv
`timescale 1ns/1ps
module sleep_timer_wake_bench;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tickEn = 1'b0;
  logic dbgClkPin = 1'b1, pwrDown = 1'b0, dbgEnable = 1'b0, lpClkSts = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic irq, wakeReq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct {
    int kind;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  sleep_timer_wake u_sleep_timer_wake (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tickEn(tickEn), .dbgClkPin(dbgClkPin), .pwrDown(pwrDown),
    .dbgEnable(dbgEnable), .lpClkSts(lpClkSts), .irq(irq), .wakeReq(wakeReq)
  );

  // monitor: kind 0 = rdData, 1 = irq, 2 = wakeReq
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = (it.kind == 0) ? rdData : (it.kind == 1) ? {31'b0, irq} : {31'b0, wakeReq};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #1 tickEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk(0, 4'h0, 32'h0, "R1 ctl1 reset");
    chk(0, 4'h4, 32'h0, "R1 ctl2 reset");
    chk(0, 4'h8, 32'h0, "R1 count reset");
    chk(1, 4'h0, 32'h0, "R1 irq reset");
    chk(2, 4'h0, 32'h0, "R1 wake reset");

    wr(4'h8, 32'h1234_5678);
    chk(0, 4'h8, 32'h1234_5678, "R2 load count");
    wr(4'h8, 32'd10);
    chk(0, 4'h8, 32'd10, "R2 reload count");

    wr(4'h4, 32'h4);
    chk(0, 4'h4, 32'h4, "R5 set pending");
    chk(0, 4'h4, 32'h1, "R5 set taken");
    chk(2, 4'h0, 32'h1, "R10 wake from irq");
    wr(4'h4, 32'h0);
    chk(0, 4'h4, 32'h1, "R5 R6 zero write ignored");

    wr(4'h4, 32'h2);
    chk(0, 4'h4, 32'h3, "R6 clear pending");
    chk(0, 4'h4, 32'h0, "R6 clear taken");
    chk(2, 4'h0, 32'h0, "R10 wake low");

    wr(4'h4, 32'h6);
    chk(0, 4'h4, 32'h6, "R8 both pending");
    chk(0, 4'h4, 32'h3, "R8 set first");
    chk(0, 4'h4, 32'h0, "R8 clear after");

    wr(4'h8, 32'd1);
    chk(0, 4'h8, 32'd1, "R4 count at one");
    chk(0, 4'h4, 32'h1, "R4 expiry sets irq");
    wr(4'h4, 32'h2);
    chk(0, 4'h4, 32'h3, "R7 clear blocked");
    chk(0, 4'h4, 32'h3, "R7 clear still blocked");
    wr(4'h8, 32'd5);
    chk(0, 4'h4, 32'h3, "R7 clear one edge late");
    chk(0, 4'h4, 32'h0, "R7 clear released");

    wr(4'h8, 32'd3);
    wr(4'h0, 32'h1);
    ticks(2);
    chk(0, 4'h8, 32'd1, "R3 two decrements");
    chk(1, 4'h0, 32'h1, "R4 irq from countdown");
    ticks(2);
    chk(0, 4'h8, 32'hFFFF_FFFF, "R3 wrap through zero");
    chk(0, 4'h0, 32'hA1, "R3 R11 ctl1 sign and active");
    chk(0, 4'h4, 32'hA1, "R3 ctl2 sign and active");
    wr(4'h0, 32'h0);
    ticks(3);
    chk(0, 4'h8, 32'hFFFF_FFFF, "R3 hold when disabled");

    wr(4'h8, 32'd10);
    lpClkSts = 1'b1;
    wr(4'h0, 32'h0100_0301);
    chk(0, 4'h0, 32'h0100_03C1, "R11 ctl1 fields");
    wr(4'h0, 32'h0);
    lpClkSts = 1'b0;
    chk(0, 4'h0, 32'h0, "R11 ctl1 cleared");
    wr(4'h4, 32'h2);
    chk(0, 4'h4, 32'h3, "R6 clear pending again");
    chk(0, 4'h4, 32'h0, "R6 irq clear");

    wr(4'h0, 32'h0100_0000);
    pwrDown = 1'b1; dbgEnable = 1'b1;
    dbgClkPin = 1'b0;
    idle(5);
    chk(0, 4'h4, 32'h100, "R9 flag on falling edge");
    chk(2, 4'h0, 32'h1, "R10 wake from debug flag");
    chk(1, 4'h0, 32'h0, "R10 irq stays low");
    wr(4'h4, 32'h100);
    chk(0, 4'h4, 32'h0, "R9 write one clears flag");
    chk(2, 4'h0, 32'h0, "R10 wake drops");

    dbgClkPin = 1'b1; idle(5);
    dbgEnable = 1'b0;
    dbgClkPin = 1'b0; idle(5);
    chk(0, 4'h4, 32'h0, "R9 gated by strap");

    dbgClkPin = 1'b1; idle(5);
    dbgEnable = 1'b1; pwrDown = 1'b0;
    dbgClkPin = 1'b0; idle(5);
    chk(0, 4'h4, 32'h0, "R9 gated by power state");

    dbgClkPin = 1'b1; idle(5);
    pwrDown = 1'b1;
    wr(4'h0, 32'h0);
    dbgClkPin = 1'b0; idle(5);
    chk(0, 4'h4, 32'h0, "R9 gated by enable bit");
    chk(2, 4'h0, 32'h0, "R9 no wake when gated");

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule